// File: doc/BRIEF.md
# Host Command Mailbox with Update-Mode Handshake

This block is a byte mailbox between a host I/O bus and an embedded controller. The host side uses an address, a read strobe, a write strobe and 8-bit data, following the legacy keyboard-controller convention. Port 0x60 carries data and port 0x64 carries commands and status. Each direction holds exactly one byte. A status byte shows whether either buffer is occupied. The controller side has its own read and write strobes. It takes host bytes from the input buffer and places reply bytes in the output buffer.

The mailbox also handles two commands itself, with no controller firmware involved. Command 0xB4 enters update mode and answers with the acknowledge byte 0xFA. Command 0xFE leaves update mode. If 0xFE arrives while the block is not in update mode, it means a system reset request instead, and the block shows it as a one-cycle pulse. A host write made while the input buffer is still full is lost, and it sets a sticky overrun flag.

Top module: `kbc_mailbox`

## Requirements
- R1: After reset, the status byte read at port 0x64 is 0x00, and `update_mode`, `sys_reset_req` and `overrun` are low.
- R2: A host write to port 0x60 or port 0x64 while the input buffer is empty stores the byte and sets status bit 1 (input full) on the next edge. Status bit 3 is then 1 if the byte came through port 0x64 and 0 if it came through port 0x60.
- R3: When the input buffer is full, `ec_in_data` shows the stored byte. An `ec_rd` pulse clears status bit 1 at the edge that ends the pulse.
- R4: An `ec_wr` while the output buffer is empty stores `ec_wdata` and sets status bit 0 (output full). A host read of port 0x60 returns that byte in the same cycle and clears bit 0 at the edge that ends the read. A host read of port 0x64 returns the status byte and changes nothing.
- R5: A byte 0xB4 written to port 0x64 is taken one clock after input-full sets. On that edge input-full clears, update mode sets (status bit 2 and `update_mode`), and the output buffer is loaded with 0xFA with bit 0 set. The 0xFA replaces any byte already waiting in the output buffer.
- R6: A byte 0xFE written to port 0x64 while in update mode is taken one clock after input-full sets. Update mode clears on that edge, no reset pulse is produced, and no byte is placed in the output buffer.
- R7: A host write while input-full is set is dropped, and the stored byte is unchanged. The drop sets status bit 4 and `overrun`, which stay set until reset.
- R8: Any other byte written to port 0x64 is not taken by the block. It stays in the input buffer with input-full set until an `ec_rd`.
- R9: A byte 0xFE taken while not in update mode drives `sys_reset_req` high for exactly one cycle, starting at the consumption edge. Update mode stays clear.
- R10: An `ec_wr` while the output buffer is full is dropped, and the held byte is kept.
- R11: Host read and write strobes to any address other than 0x60 and 0x64 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W | Host I/O address |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational) |
| ec_rd | input | 1 | Controller takes the input-buffer byte |
| ec_in_data | output | 8 | Input-buffer byte |
| ec_in_is_cmd | output | 1 | Input-buffer byte came through the command port |
| ec_ibf | output | 1 | Input buffer full |
| ec_wr | input | 1 | Controller writes the output buffer |
| ec_wdata | input | 8 | Controller reply byte |
| ec_obf | output | 1 | Output buffer full |
| update_mode | output | 1 | Update mode active |
| sys_reset_req | output | 1 | One-cycle system reset request |
| overrun | output | 1 | Sticky dropped-host-write flag |

## Verification
The bench sends data-port bytes, the enter command, the exit command and an unrecognised command through the mailbox. This shows which bytes the block takes itself and which it leaves for the controller. Status is read back after each step. Bit 3 separates command bytes from data bytes, and bit 2 tracks the mode through a full enter and exit. A second host write and a second controller write, each made while its buffer is full, check that the first byte survives. A 0xFE sent outside update mode, with the reset pulse counted, separates the exit path from the reset path. Strobes to an unrelated address confirm that nothing changes.

// File: rtl/kbc_mbox_pkg.sv
package kbc_mbox_pkg;
  localparam int BYTE_W = 8;

  // status byte bit positions (host software decodes these)
  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_UPD = 2;
  localparam int ST_CMD = 3;
  localparam int ST_OVR = 4;

  function automatic logic [BYTE_W-1:0] pack_status(
    input logic obf, input logic ibf, input logic upd,
    input logic cmd, input logic ovr);
    logic [BYTE_W-1:0] s;
    s = '0;
    s[ST_OBF] = obf;
    s[ST_IBF] = ibf;
    s[ST_UPD] = upd;
    s[ST_CMD] = cmd;
    s[ST_OVR] = ovr;
    return s;
  endfunction
endpackage

// File: rtl/kbc_in_buf.sv
module kbc_in_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic         wr_is_cmd,
  input  logic [W-1:0] wr_data,
  input  logic         consume,
  output logic         ibf,
  output logic [W-1:0] ib_data,
  output logic         ib_cmd,
  output logic         overrun,
  output logic         wr_accept,
  output logic         wr_drop
);
  assign wr_accept = wr_hit & ~ibf;
  assign wr_drop   = wr_hit & ibf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ibf     <= 1'b0;
      ib_data <= '0;
      ib_cmd  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (wr_accept) begin
        ibf     <= 1'b1;
        ib_data <= wr_data;
        ib_cmd  <= wr_is_cmd;
      end else if (consume) begin
        ibf <= 1'b0;
      end
      if (wr_drop) overrun <= 1'b1;
    end
  end

  // R7
  drop_keeps_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> (ibf && $stable(ib_data)));
  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R3
  consume_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && ibf) |=> !ibf);
endmodule

// File: rtl/kbc_out_buf.sv
module kbc_out_buf #(
  parameter int          W   = 8,
  parameter logic [W-1:0] ACK = 8'hFA
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ack_load,
  input  logic         ec_wr,
  input  logic [W-1:0] ec_wdata,
  input  logic         host_take,
  output logic         obf,
  output logic [W-1:0] ob_data
);
  logic ec_load;
  assign ec_load = ec_wr & ~obf & ~ack_load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obf     <= 1'b0;
      ob_data <= '0;
    end else if (ack_load) begin
      obf     <= 1'b1;
      ob_data <= ACK;
    end else if (ec_load) begin
      obf     <= 1'b1;
      ob_data <= ec_wdata;
    end else if (host_take) begin
      obf <= 1'b0;
    end
  end

  // R4
  host_take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_take && !ack_load) |=> !obf);
  // R10
  ec_wr_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ec_wr && obf && !ack_load && !host_take) |=> (obf && $stable(ob_data)));
endmodule

// File: rtl/kbc_cmd_dec.sv
module kbc_cmd_dec #(
  parameter int           W         = 8,
  parameter logic [W-1:0] CMD_ENTER = 8'hB4,
  parameter logic [W-1:0] CMD_EXIT  = 8'hFE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ibf,
  input  logic         ib_cmd,
  input  logic [W-1:0] ib_data,
  output logic         cmd_take,
  output logic         enter_evt,
  output logic         reset_evt,
  output logic         upd_mode,
  output logic         sys_reset_req
);
  logic pending_cmd;
  logic exit_evt;

  assign pending_cmd = ibf & ib_cmd;
  assign enter_evt   = pending_cmd & (ib_data == CMD_ENTER);
  assign exit_evt    = pending_cmd & (ib_data == CMD_EXIT) & upd_mode;
  assign reset_evt   = pending_cmd & (ib_data == CMD_EXIT) & ~upd_mode;
  assign cmd_take    = enter_evt | exit_evt | reset_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_mode      <= 1'b0;
      sys_reset_req <= 1'b0;
    end else begin
      if (enter_evt)     upd_mode <= 1'b1;
      else if (exit_evt) upd_mode <= 1'b0;
      sys_reset_req <= reset_evt;
    end
  end

  // R5
  enter_sets_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_evt |=> upd_mode);
  // R6
  exit_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_evt |=> (!upd_mode && !sys_reset_req));
  // R9
  reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_evt |=> (sys_reset_req && !upd_mode));
  // R9
  reset_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |=> !sys_reset_req);
endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox #(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] DATA_PORT = 8'h60,
  parameter logic [ADDR_W-1:0] CMD_PORT  = 8'h64,
  parameter logic [7:0]        CMD_ENTER = 8'hB4,
  parameter logic [7:0]        CMD_EXIT  = 8'hFE,
  parameter logic [7:0]        ACK_BYTE  = 8'hFA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              ec_rd,
  output logic [7:0]        ec_in_data,
  output logic              ec_in_is_cmd,
  output logic              ec_ibf,
  input  logic              ec_wr,
  input  logic [7:0]        ec_wdata,
  output logic              ec_obf,
  output logic              update_mode,
  output logic              sys_reset_req,
  output logic              overrun
);
  import kbc_mbox_pkg::*;
  localparam int W = BYTE_W;

  logic         sel_data, sel_cmd;
  logic         wr_hit, wr_accept, wr_drop;
  logic         host_take;
  logic         ibf, ib_cmd, obf;
  logic [W-1:0] ib_data, ob_data;
  logic         cmd_take, enter_evt, reset_evt;
  logic         consume;

  assign sel_data  = (host_addr == DATA_PORT);
  assign sel_cmd   = (host_addr == CMD_PORT);
  assign wr_hit    = host_wr & (sel_data | sel_cmd);
  assign host_take = host_rd & sel_data & obf;
  assign consume   = ec_rd | cmd_take;

  kbc_in_buf #(.W(W)) in_buf_i (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_is_cmd(sel_cmd),
    .wr_data(host_wdata), .consume(consume), .ibf(ibf), .ib_data(ib_data),
    .ib_cmd(ib_cmd), .overrun(overrun), .wr_accept(wr_accept),
    .wr_drop(wr_drop));

  kbc_cmd_dec #(.W(W), .CMD_ENTER(CMD_ENTER), .CMD_EXIT(CMD_EXIT)) dec_i (
    .clk(clk), .rst_n(rst_n), .ibf(ibf), .ib_cmd(ib_cmd), .ib_data(ib_data),
    .cmd_take(cmd_take), .enter_evt(enter_evt), .reset_evt(reset_evt),
    .upd_mode(update_mode), .sys_reset_req(sys_reset_req));

  kbc_out_buf #(.W(W), .ACK(ACK_BYTE)) out_buf_i (
    .clk(clk), .rst_n(rst_n), .ack_load(enter_evt), .ec_wr(ec_wr),
    .ec_wdata(ec_wdata), .host_take(host_take), .obf(obf), .ob_data(ob_data));

  always_comb begin
    host_rdata = '0;
    if (host_rd && sel_data)     host_rdata = ob_data;
    else if (host_rd && sel_cmd) host_rdata = pack_status(obf, ibf, update_mode, ib_cmd, overrun);
  end

  assign ec_in_data   = ib_data;
  assign ec_in_is_cmd = ib_cmd;
  assign ec_ibf       = ibf;
  assign ec_obf       = obf;

  // R2
  accept_sets_ibf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> (ibf && ib_cmd == $past(sel_cmd)));
  // R11
  foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_wr || host_rd) && !sel_data && !sel_cmd && !ec_rd && !ec_wr && !cmd_take)
      |=> ($stable(ibf) && $stable(obf) && $stable(overrun)));
  // R5
  enter_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_evt |=> (obf && ob_data == ACK_BYTE && !ibf));
endmodule

// File: tb/kbc_mailbox_tb_top.sv
module kbc_mailbox_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] host_addr, host_wdata, host_rdata, ec_in_data, ec_wdata;
  logic       host_rd, host_wr, ec_rd, ec_wr;
  logic       ec_in_is_cmd, ec_ibf, ec_obf, update_mode, sys_reset_req, overrun;

  int checks = 0;
  int errors = 0;
  int rst_pulses = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  kbc_mailbox dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ec_rd(ec_rd), .ec_in_data(ec_in_data), .ec_in_is_cmd(ec_in_is_cmd),
    .ec_ibf(ec_ibf), .ec_wr(ec_wr), .ec_wdata(ec_wdata), .ec_obf(ec_obf),
    .update_mode(update_mode), .sys_reset_req(sys_reset_req), .overrun(overrun));

  always @(negedge clk) if (rst_n && sys_reset_req) rst_pulses++;

  // vector: op(3) addr(8) data(8) expected(8) requirement(8)
  // op 0 idle, 1 host write, 2 host read+compare, 3 ec read+compare, 4 ec write
  localparam int NV = 23;
  localparam logic [34:0] VEC [NV] = '{
    {3'd2, 8'h64, 8'h00, 8'h00, 8'd1},   // R1 reset status
    {3'd1, 8'h60, 8'h5A, 8'h00, 8'd2},
    {3'd2, 8'h64, 8'h00, 8'h02, 8'd2},   // R2 input full, data port
    {3'd1, 8'h60, 8'h33, 8'h00, 8'd7},   // dropped
    {3'd2, 8'h64, 8'h00, 8'h12, 8'd7},   // R7 overrun set
    {3'd3, 8'h00, 8'h00, 8'h5A, 8'd3},   // R3 first byte kept
    {3'd2, 8'h64, 8'h00, 8'h10, 8'd3},
    {3'd4, 8'h00, 8'hC3, 8'h00, 8'd4},
    {3'd2, 8'h64, 8'h00, 8'h11, 8'd4},   // R4 output full
    {3'd2, 8'h60, 8'h00, 8'hC3, 8'd4},
    {3'd2, 8'h64, 8'h00, 8'h10, 8'd4},
    {3'd1, 8'h64, 8'hB4, 8'h00, 8'd5},
    {3'd0, 8'h00, 8'h00, 8'h00, 8'd5},
    {3'd2, 8'h64, 8'h00, 8'h1D, 8'd5},   // R5 mode + ack pending
    {3'd2, 8'h60, 8'h00, 8'hFA, 8'd5},
    {3'd1, 8'h64, 8'hFE, 8'h00, 8'd6},
    {3'd0, 8'h00, 8'h00, 8'h00, 8'd6},
    {3'd2, 8'h64, 8'h00, 8'h18, 8'd6},   // R6 mode cleared, no ack
    {3'd1, 8'h64, 8'h20, 8'h00, 8'd8},
    {3'd0, 8'h00, 8'h00, 8'h00, 8'd8},
    {3'd2, 8'h64, 8'h00, 8'h1A, 8'd8},   // R8 still pending
    {3'd3, 8'h00, 8'h00, 8'h20, 8'd8},
    {3'd2, 8'h64, 8'h00, 8'h18, 8'd8}
  };

  task automatic check(input bit ok, input int req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    host_rd = 0; host_wr = 0; ec_rd = 0; ec_wr = 0;
    host_addr = 8'h00; host_wdata = 8'h00; ec_wdata = 8'h00;
  endtask

  // drives one cycle starting at a falling edge, compares, then returns at the next falling edge
  task automatic step(input logic [2:0] op, input logic [7:0] a, input logic [7:0] d,
                      input logic [7:0] exp, input int req);
    idle_inputs();
    host_addr = a;
    case (op)
      3'd1: begin host_wr = 1; host_wdata = d; end
      3'd2: host_rd = 1;
      3'd3: ec_rd = 1;
      3'd4: begin ec_wr = 1; ec_wdata = d; end
      default: ;
    endcase
    #1;
    if (op == 3'd2) check(host_rdata == exp, req, host_rdata, exp);
    if (op == 3'd3) check(ec_ibf && ec_in_data == exp, req, ec_in_data, exp);
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset outputs
    check(!update_mode && !sys_reset_req && !overrun, 1, {update_mode, sys_reset_req, overrun}, 0);

    for (int i = 0; i < NV; i++)
      step(VEC[i][34:32], VEC[i][31:24], VEC[i][23:16], VEC[i][15:8], int'(VEC[i][7:0]));

    // R6 exit inside update mode produced no reset pulse
    check(rst_pulses == 0, 6, rst_pulses, 0);

    // R9 0xFE outside update mode: one pulse, mode stays clear
    step(3'd1, 8'h64, 8'hFE, 8'h00, 9);
    repeat (4) step(3'd0, 8'h00, 8'h00, 8'h00, 9);
    check(rst_pulses == 1, 9, rst_pulses, 1);
    check(!update_mode, 9, update_mode, 0);

    // R10 controller write into a full output buffer is dropped
    step(3'd4, 8'h00, 8'h11, 8'h00, 10);
    step(3'd4, 8'h00, 8'h22, 8'h00, 10);
    step(3'd2, 8'h60, 8'h00, 8'h11, 10);

    // R11 strobes to another address change nothing
    step(3'd1, 8'h70, 8'h99, 8'h00, 11);
    step(3'd2, 8'h70, 8'h00, 8'h00, 11);
    step(3'd2, 8'h64, 8'h00, 8'h18, 11);

    // R1 reset clears sticky overrun and mode
    step(3'd1, 8'h64, 8'hB4, 8'h00, 1);
    step(3'd0, 8'h00, 8'h00, 8'h00, 1);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    step(3'd2, 8'h64, 8'h00, 8'h00, 1);
    check(!update_mode && !overrun && !ec_obf, 1, {update_mode, overrun, ec_obf}, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule